// File: doc/BRIEF.md
# Sync Pin Event Detector

This block turns a few external synchronization pins into per-channel timing events. Each raw pin first goes through a two-flop synchronizer. It is then examined either for a rising edge or for a high level, and it is masked by its own pin enable. For each of six channels, the block selects the one pin that the channel listens to. From that pin it forms two event pulses: a start event and a hop event. Each pulse reaches the channel only if that channel has opted into pin-driven operation for that event type, and only if the matching global enable is set.

A first-event-only mode lets a single event through and then locks out everything that follows. The lock holds as long as the mode bit stays set. Clearing the bit, or resetting the block, re-arms it. The outputs are registered one-cycle pulses, intended for the oscillator phase logic of each channel. The block carries no data stream, so every port is a plain control or status pin with no handshake.

Top module: `sync_event_detector`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, all start and hop outputs are 0.
- R2: A pin that goes high while idle produces its first output pulse on the third rising clock edge after the change: two synchronizer stages plus one output register.
- R3: With `cfg_edge_mode_i` = 0 (level mode), a channel pulses on every cycle that its selected pin is sampled high. A pin held high for N edges gives exactly N pulses.
- R4: With `cfg_edge_mode_i` = 1 (edge mode), each low-to-high transition gives exactly one single-cycle pulse, however long the pin then stays high.
- R5: A pin whose bit in `cfg_pin_en_i` is 0 produces no events on any channel.
- R6: Channel c listens only to the pin whose number equals `ch_pin_sel_i[2c+1:2c]`.
- R7: With `cfg_start_en_i` = 0, `start_pulse_o` stays 0, while hop events still pass.
- R8: With `cfg_hop_en_i` = 0, `hop_pulse_o` stays 0, while start events still pass.
- R9: Bit c of `ch_start_pin_mode_i` / `ch_hop_pin_mode_i` must be 1 for channel c to receive start / hop events.
- R10: With `cfg_first_only_i` = 1, only the first cycle that carries any event produces pulses. Every later event is blocked while the bit stays 1. Clearing the bit re-arms the block.
- R11: One pin event reaches, in the same cycle, every channel that selects that pin and has the matching mode bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_pin_i | input | 4 | Raw external sync pins |
| cfg_hop_en_i | input | 1 | Global hop-event enable |
| cfg_start_en_i | input | 1 | Global start-event enable |
| cfg_first_only_i | input | 1 | Accept only the first event |
| cfg_edge_mode_i | input | 1 | 1 = rising edge, 0 = high level |
| cfg_pin_en_i | input | 4 | Per-pin enable |
| ch_pin_sel_i | input | 12 | 2-bit pin number per channel, channel c at bits 2c+1:2c |
| ch_start_pin_mode_i | input | 6 | Per-channel start pin-sync opt-in |
| ch_hop_pin_mode_i | input | 6 | Per-channel hop pin-sync opt-in |
| start_pulse_o | output | 6 | Per-channel start event pulse |
| hop_pulse_o | output | 6 | Per-channel hop event pulse |

## Verification
The bench drives short pulses and long high stretches on single pins.

- Long high stretches separate edge detection (one pulse) from level detection (one pulse per high cycle).
- The cycle of the first pulse pins down the three-edge latency.
- Mixed pin-select maps and mixed mode masks show that each event lands only on channels that chose its pin and opted in.
- Toggling the global gates one at a time shows that start and hop are gated independently.
- A repeated pulse train under the first-only mode, in both detection modes, shows that the lockout blocks later events and that clearing the mode bit re-arms it.

// File: rtl/sync_det_pkg.sv
package sync_det_pkg;
  localparam int unsigned SD_PINS  = 4;
  localparam int unsigned SD_CHANS = 6;
endpackage

// File: rtl/sd_pin_front.sv
module sd_pin_front #(
  parameter int unsigned NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                edge_mode_i,
  input  logic [NUM_PINS-1:0] pin_en_i,
  output logic [NUM_PINS-1:0] evt_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pins_i[p];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    always_comb begin
      if (edge_mode_i) evt_o[p] = pin_en_i[p] & sync_q & ~prev_q;
      else             evt_o[p] = pin_en_i[p] & sync_q;
    end
  end
endmodule

// File: rtl/sd_chan_route.sv
module sd_chan_route #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned NUM_CH   = 6,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic [NUM_PINS-1:0]     pin_evt_i,
  input  logic [NUM_CH*SEL_W-1:0] sel_i,
  input  logic                    start_en_i,
  input  logic                    hop_en_i,
  input  logic [NUM_CH-1:0]       start_mode_i,
  input  logic [NUM_CH-1:0]       hop_mode_i,
  output logic [NUM_CH-1:0]       start_o,
  output logic [NUM_CH-1:0]       hop_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SEL_W-1:0] sel;
    logic             pev;
    assign sel = sel_i[c*SEL_W +: SEL_W];
    always_comb begin
      pev = 1'b0;
      for (int p = 0; p < NUM_PINS; p++) begin
        if (int'(sel) == p) pev = pin_evt_i[p];
      end
    end
    assign start_o[c] = start_en_i & start_mode_i[c] & pev;
    assign hop_o[c]   = hop_en_i & hop_mode_i[c] & pev;
  end
endmodule

// File: rtl/sd_first_gate.sv
module sd_first_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic first_only_i,
  input  logic event_any_i,
  output logic pass_o
);
  logic lock_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= first_only_i & (lock_q | event_any_i);
  end
  assign pass_o = ~(first_only_i & lock_q);
endmodule

// File: rtl/sync_event_detector.sv
module sync_event_detector
  import sync_det_pkg::*;
#(
  parameter int unsigned NUM_PINS = SD_PINS,
  parameter int unsigned NUM_CH   = SD_CHANS,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_PINS-1:0]     sync_pin_i,
  input  logic                    cfg_hop_en_i,
  input  logic                    cfg_start_en_i,
  input  logic                    cfg_first_only_i,
  input  logic                    cfg_edge_mode_i,
  input  logic [NUM_PINS-1:0]     cfg_pin_en_i,
  input  logic [NUM_CH*SEL_W-1:0] ch_pin_sel_i,
  input  logic [NUM_CH-1:0]       ch_start_pin_mode_i,
  input  logic [NUM_CH-1:0]       ch_hop_pin_mode_i,
  output logic [NUM_CH-1:0]       start_pulse_o,
  output logic [NUM_CH-1:0]       hop_pulse_o
);
  logic [NUM_PINS-1:0] pin_evt;
  logic [NUM_CH-1:0]   raw_start, raw_hop;
  logic                pass;

  sd_pin_front #(.NUM_PINS(NUM_PINS)) u_front (
    .clk(clk), .rst_n(rst_n), .pins_i(sync_pin_i),
    .edge_mode_i(cfg_edge_mode_i), .pin_en_i(cfg_pin_en_i), .evt_o(pin_evt)
  );

  sd_chan_route #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_route (
    .pin_evt_i(pin_evt), .sel_i(ch_pin_sel_i),
    .start_en_i(cfg_start_en_i), .hop_en_i(cfg_hop_en_i),
    .start_mode_i(ch_start_pin_mode_i), .hop_mode_i(ch_hop_pin_mode_i),
    .start_o(raw_start), .hop_o(raw_hop)
  );

  sd_first_gate u_gate (
    .clk(clk), .rst_n(rst_n), .first_only_i(cfg_first_only_i),
    .event_any_i((|raw_start) | (|raw_hop)), .pass_o(pass)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_pulse_o <= '0;
      hop_pulse_o   <= '0;
    end else begin
      start_pulse_o <= raw_start & {NUM_CH{pass}};
      hop_pulse_o   <= raw_hop & {NUM_CH{pass}};
    end
  end
endmodule

// File: rtl/sd_checker.sv
module sd_checker #(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned NUM_CH   = 6,
  localparam int unsigned SEL_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_hop_en_i,
  input logic                    cfg_start_en_i,
  input logic                    cfg_first_only_i,
  input logic                    cfg_edge_mode_i,
  input logic [NUM_PINS-1:0]     cfg_pin_en_i,
  input logic [NUM_CH*SEL_W-1:0] ch_pin_sel_i,
  input logic [NUM_CH-1:0]       ch_start_pin_mode_i,
  input logic [NUM_CH-1:0]       ch_hop_pin_mode_i,
  input logic [NUM_CH-1:0]       start_pulse_o,
  input logic [NUM_CH-1:0]       hop_pulse_o
);
  logic any_out;
  assign any_out = (|start_pulse_o) | (|hop_pulse_o);

  a_r8_hop_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hop_en_i |=> hop_pulse_o == '0);

  a_r7_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_start_en_i |=> start_pulse_o == '0);

  a_r9_mode_optin: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((start_pulse_o & ~$past(ch_start_pin_mode_i)) == '0) &&
             ((hop_pulse_o & ~$past(ch_hop_pin_mode_i)) == '0));

  a_r5_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_pin_en_i == '0) |=> !any_out);

  a_r10_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (any_out && cfg_first_only_i && $past(cfg_first_only_i)) |=> !any_out);

  a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_edge_mode_i && $past(cfg_edge_mode_i) && $stable(ch_pin_sel_i))
      |=> ((start_pulse_o & $past(start_pulse_o)) == '0) &&
          ((hop_pulse_o & $past(hop_pulse_o)) == '0));
endmodule

bind sync_event_detector sd_checker #(.NUM_PINS(NUM_PINS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cfg_hop_en_i(cfg_hop_en_i), .cfg_start_en_i(cfg_start_en_i),
  .cfg_first_only_i(cfg_first_only_i), .cfg_edge_mode_i(cfg_edge_mode_i),
  .cfg_pin_en_i(cfg_pin_en_i), .ch_pin_sel_i(ch_pin_sel_i),
  .ch_start_pin_mode_i(ch_start_pin_mode_i), .ch_hop_pin_mode_i(ch_hop_pin_mode_i),
  .start_pulse_o(start_pulse_o), .hop_pulse_o(hop_pulse_o)
);

// File: tb/test_sync_event_detector.sv
module test_sync_event_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  pins = '0;
  logic        hop_en = 1'b1, start_en = 1'b1, first_only = 1'b0, edge_mode = 1'b1;
  logic [3:0]  pin_en = 4'hF;
  logic [11:0] sel = '0;
  logic [5:0]  smode = 6'h3F, hmode = 6'h3F;
  logic [5:0]  sp, hp;
  int          cnt_s[6], cnt_h[6];
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  sync_event_detector i_sync_event_detector (
    .clk(clk), .rst_n(rst_n), .sync_pin_i(pins),
    .cfg_hop_en_i(hop_en), .cfg_start_en_i(start_en),
    .cfg_first_only_i(first_only), .cfg_edge_mode_i(edge_mode),
    .cfg_pin_en_i(pin_en), .ch_pin_sel_i(sel),
    .ch_start_pin_mode_i(smode), .ch_hop_pin_mode_i(hmode),
    .start_pulse_o(sp), .hop_pulse_o(hp)
  );

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic clr_counts();
    for (int c = 0; c < 6; c++) begin cnt_s[c] = 0; cnt_h[c] = 0; end
  endtask

  task automatic step();
    @(negedge clk);
    for (int c = 0; c < 6; c++) begin
      cnt_s[c] += int'(sp[c]);
      cnt_h[c] += int'(hp[c]);
    end
  endtask

  task automatic set_sel(int a0, int a1, int a2, int a3, int a4, int a5);
    sel = {a5[1:0], a4[1:0], a3[1:0], a2[1:0], a1[1:0], a0[1:0]};
  endtask

  // raise pin p for 'hold' sampling edges, then wait long enough to drain
  task automatic pulse_pin(int p, int hold);
    pins[p] = 1'b1;
    for (int i = 0; i < hold; i++) step();
    pins[p] = 1'b0;
    for (int i = 0; i < 6; i++) step();
  endtask

  task automatic chk_counts(string r, logic [5:0] sm, logic [5:0] hm, int n);
    for (int c = 0; c < 6; c++) begin
      chk({r, " start"}, cnt_s[c], sm[c] ? n : 0);
      chk({r, " hop"}, cnt_h[c], hm[c] ? n : 0);
    end
  endtask

  task automatic t_reset();
    step();
    chk("R1 start in reset", int'(sp), 0);
    chk("R1 hop in reset", int'(hp), 0);
    rst_n = 1'b1;
    step();
    chk("R1 start after reset", int'(sp), 0);
    chk("R1 hop after reset", int'(hp), 0);
  endtask

  task automatic t_latency_edge();
    set_sel(0, 1, 2, 3, 0, 1);
    edge_mode = 1'b1;
    step();
    clr_counts();
    pins[0] = 1'b1;
    step(); chk("R2 no pulse edge1", int'(sp | hp), 0);
    step(); chk("R2 no pulse edge2", int'(sp | hp), 0);
    step(); chk("R2 R11 start at edge3", int'(sp), 6'b010001);
    chk("R2 R11 hop at edge3", int'(hp), 6'b010001);
    for (int i = 0; i < 5; i++) step();
    pins[0] = 1'b0;
    for (int i = 0; i < 6; i++) step();
    chk_counts("R4 held high one pulse", 6'b010001, 6'b010001, 1);
  endtask

  task automatic t_level();
    edge_mode = 1'b0;
    step();
    clr_counts();
    pulse_pin(1, 4);
    chk_counts("R3 level pulses", 6'b100010, 6'b100010, 4);
    edge_mode = 1'b1;
  endtask

  task automatic t_pin_enable();
    pin_en = 4'b1011;
    step(); clr_counts();
    pulse_pin(2, 3);
    chk_counts("R5 disabled pin", 6'b0, 6'b0, 0);
    pin_en = 4'hF;
    step(); clr_counts();
    pulse_pin(2, 3);
    chk_counts("R5 re-enabled pin", 6'b000100, 6'b000100, 1);
  endtask

  task automatic t_select();
    set_sel(3, 3, 3, 0, 3, 3);
    step(); clr_counts();
    pulse_pin(0, 2);
    chk_counts("R6 only ch3 on pin0", 6'b001000, 6'b001000, 1);
    step(); clr_counts();
    pulse_pin(3, 2);
    chk_counts("R6 R11 pin3 others", 6'b110111, 6'b110111, 1);
  endtask

  task automatic t_gates();
    set_sel(0, 0, 0, 0, 0, 0);
    start_en = 1'b0;
    step(); clr_counts();
    pulse_pin(0, 2);
    chk_counts("R7 start gated", 6'b0, 6'h3F, 1);
    start_en = 1'b1; hop_en = 1'b0;
    step(); clr_counts();
    pulse_pin(0, 2);
    chk_counts("R8 hop gated", 6'h3F, 6'b0, 1);
    hop_en = 1'b1;
  endtask

  task automatic t_modes();
    smode = 6'b000101; hmode = 6'b110000;
    step(); clr_counts();
    pulse_pin(0, 2);
    chk_counts("R9 mode opt-in", 6'b000101, 6'b110000, 1);
    smode = 6'h3F; hmode = 6'h3F;
  endtask

  task automatic t_first_only();
    first_only = 1'b1;
    step(); clr_counts();
    pulse_pin(0, 2);
    pulse_pin(0, 2);
    pulse_pin(1, 2);
    chk_counts("R10 edge first only", 6'h3F, 6'h3F, 1);
    first_only = 1'b0;
    step(); step();
    first_only = 1'b1; edge_mode = 1'b0;
    step(); clr_counts();
    pulse_pin(0, 5);
    chk_counts("R10 level first only", 6'h3F, 6'h3F, 1);
    first_only = 1'b0;
    step(); step(); clr_counts();
    pulse_pin(0, 3);
    chk_counts("R10 re-armed level", 6'h3F, 6'h3F, 3);
    edge_mode = 1'b1;
  endtask

  initial begin
    t_reset();
    t_latency_edge();
    t_level();
    t_pin_enable();
    t_select();
    t_gates();
    t_modes();
    t_first_only();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule